// File: doc/BRIEF.md
# Command-Unit List Sequencer

This block serves channel-attention strobes for a controller whose control and status are kept in shared memory and not in registers. On each strobe it fetches the control word from a control block in memory and writes zero back over it. It then clears the status events that software acknowledged and moves the command unit and the receive unit to their new states. When the command unit is active, it walks a singly linked chain of command blocks. For each block it posts a busy word, hands the block to an external action unit picked by a 3-bit opcode, posts a completion word and follows the link.

The walk ends at a null link, at a block flagged as last, or at a block that asks the unit to suspend. After the control word is handled, and again after every block, the status word at the base of the control block is rewritten. It carries the event bits and both unit states. A block can ask for an interrupt. That sets the top event bit and gives a one-cycle pulse on `irq`. A strobe that arrives during a walk is counted and served once the walk is over.

All accesses are 16-bit words at byte addresses. A 32-bit pointer is stored low half first, at the lower address. Only the low `ADDR_W` bits of a pointer are used to address memory.

Top module: `cuseq_top`

## Requirements
- R1: After reset, `mem_req`, `irq` and `act_start` are low. The command unit is idle (code 0), the receive unit is suspended (code 1), all four event bits are clear and the command pointer is null, so the first status word written without a state change is 16'h0010.
- R2: Each served strobe reads the control word at base+2, then writes 16'h0000 to base+2.
- R3: Each bit set in control-word bits 15:12 clears the same event bit. Event bits sit at status bits 15:12.
- R4: Command-unit code (control bits 10:8) 1 makes the unit active (2). Code 4 suspends it (1) and sets event bit 13. Every other code changes neither the state nor any event.
- R5: Receive-unit code (control bits 6:4) 1 or 2 sets the receiver to idle (0). Code 3 or 4 suspends it (1) and sets event bit 12. Other codes change nothing.
- R6: The status word written to base+0 is {events[15:12], 2'b00, command-unit state in bits 9:8, 1'b0, receive-unit state in bits 6:4, 4'b0000}. It is written after the control word is handled and after every block.
- R7: For each block, 16'h4000 is written to block+0 before the action runs, and 16'hA000 is written there after the action completes. Blocks are visited in link order.
- R8: The opcode is bits 2:0 of the block word at block+2. When the opcode's bit in `OP_HS_MASK` is set, the matching `act_start` bit pulses for one cycle with `act_blk` holding the block address, and the sequencer waits for the matching `act_done` bit. Other opcodes complete at once, with no pulse.
- R9: The link is read from block+4 (low half) and block+6 (high half). A link of 0 or 32'hFFFFFFFF, or block-word bit 15, ends the walk. Block-word bit 14 suspends the command unit after the block and stops the walk. A later start resumes at the stored link.
- R10: Block-word bit 13 sets event bit 15 and pulses `irq` for one cycle. A block without it clears event bit 15.
- R11: When the command pointer is null and the command unit is not suspended after decoding, the pointer is loaded from base+4/base+6. A walk runs only while the unit is active and the pointer is not null.
- R12: Strobes arriving while a strobe is being served are counted, up to 2^CA_CNT_W-1 pending, and each is served later in turn.
- R13: Control-word bit 7 overrides the decoded codes. It clears all events, sets the command unit idle and the receive unit suspended, and makes the pointer null.
- R14: Once `mem_req` is raised, it stays high with the same address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ca | input | 1 | Channel-attention strobe, one cycle |
| cb_base | input | ADDR_W | Byte address of the control block |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 16 | Read data |
| act_start | output | 8 | One-hot start pulse per opcode |
| act_done | input | 8 | Completion pulse per opcode |
| act_blk | output | ADDR_W | Address of the block being dispatched |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong unit state shows in the next status word written to base+0. A wrong pointer or flag decision shows as busy writes to the wrong blocks, in the wrong order or in the wrong number, within one walk. A lost or extra strobe changes the number of walks, and the receive and command states left in memory. A dispatch fault shows at once as a start pulse on the wrong opcode line or at the wrong address, or as a walk that hangs waiting for completion.

// File: rtl/cuseq_pkg.sv
package cuseq_pkg;

   typedef enum logic [1:0] {
      CU_IDLE = 2'd0,
      CU_SUSP = 2'd1,
      CU_ACT  = 2'd2
   } cu_state_t;

   typedef enum logic [2:0] {
      RU_IDLE  = 3'd0,
      RU_SUSP  = 3'd1,
      RU_READY = 3'd4
   } ru_state_t;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_CW, S_WR_CW, S_HEAD_LO, S_HEAD_HI, S_WR_STAT,
      S_WR_BUSY, S_RD_BCMD, S_START, S_WAIT, S_WR_DONE, S_LNK_LO, S_LNK_HI
   } seq_state_t;

   localparam logic [15:0] BLK_BUSY_WORD = 16'h4000;
   localparam logic [15:0] BLK_DONE_WORD = 16'hA000;

   function automatic logic ptr_is_null(input logic [31:0] p);
      return (p == 32'h0) || (p == 32'hFFFF_FFFF);
   endfunction

   function automatic logic [15:0] pack_status(input logic [3:0] ev,
                                               input logic [1:0] cu,
                                               input logic [2:0] ru);
      return {ev, 2'b00, cu, 1'b0, ru, 4'b0000};
   endfunction

endpackage

// File: rtl/cuseq_ctl_decode.sv
module cuseq_ctl_decode
   import cuseq_pkg::*;
(
   input  logic [3:0] ack_bits,
   input  logic [2:0] cu_code,
   input  logic [2:0] ru_code,
   input  logic       soft_rst,
   input  logic [3:0] ev_in,
   input  cu_state_t  cu_in,
   input  ru_state_t  ru_in,
   output logic [3:0] ev_out,
   output cu_state_t  cu_out,
   output ru_state_t  ru_out
);

   always_comb begin
      ev_out = ev_in & ~ack_bits;
      cu_out = cu_in;
      ru_out = ru_in;
      case (cu_code)
         3'd1: cu_out = CU_ACT;
         3'd4: begin
            cu_out    = CU_SUSP;
            ev_out[1] = 1'b1;
         end
         default: ;
      endcase
      case (ru_code)
         3'd1, 3'd2: ru_out = RU_IDLE;
         3'd3, 3'd4: begin
            ru_out    = RU_SUSP;
            ev_out[0] = 1'b1;
         end
         default: ;
      endcase
      if (soft_rst) begin
         ev_out = 4'b0000;
         cu_out = CU_IDLE;
         ru_out = RU_SUSP;
      end
   end

endmodule

// File: rtl/cuseq_dispatch.sv
module cuseq_dispatch #(
   parameter logic [7:0] HS_MASK = 8'hFE
) (
   input  logic       go,
   input  logic [2:0] opcode,
   input  logic [7:0] done_in,
   output logic [7:0] start,
   output logic       needs_hs,
   output logic       done_hit
);

   logic [7:0] done_sel;

   for (genvar k = 0; k < 8; k++) begin : g_op
      if (HS_MASK[k]) begin : g_hs
         assign start[k] = go && (opcode == 3'(k));
      end else begin : g_imm
         assign start[k] = 1'b0;
      end
      assign done_sel[k] = HS_MASK[k] && (opcode == 3'(k)) && done_in[k];
   end

   assign needs_hs = HS_MASK[opcode];
   assign done_hit = |done_sel;

endmodule

// File: rtl/cuseq_top.sv
module cuseq_top
   import cuseq_pkg::*;
#(
   parameter int         ADDR_W     = 12,
   parameter logic [7:0] OP_HS_MASK = 8'hFE,
   parameter int         CA_CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ca,
   input  logic [ADDR_W-1:0] cb_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic [7:0]        act_start,
   input  logic [7:0]        act_done,
   output logic [ADDR_W-1:0] act_blk,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] OFS_W1 = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] OFS_W2 = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFS_W3 = ADDR_W'(6);
   localparam logic [CA_CNT_W-1:0] CA_MAX = '1;

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
      $error("cuseq_top: ADDR_W must lie in 4..32");
   end
   if (CA_CNT_W < 1 || CA_CNT_W > 16) begin : g_bad_cw
      $error("cuseq_top: CA_CNT_W must lie in 1..16");
   end

   seq_state_t          state;
   cu_state_t           cu_q, cu_d;
   ru_state_t           ru_q, ru_d;
   logic [3:0]          ev_q, ev_d;
   logic [ADDR_W-1:0]   ptr_q;
   logic                pnull_q;
   logic [15:0]         half_q;
   logic [31:0]         word32;
   logic [3:0]          cw_ack;
   logic [2:0]          cw_cuc, cw_ruc;
   logic                cw_soft;
   logic [2:0]          b_op;
   logic                b_eol, b_susp, b_intr;
   logic [CA_CNT_W-1:0] ca_cnt;
   logic                ca_take, ca_inc;
   logic                hs_need, hs_done;

   cuseq_ctl_decode u_dec (
      .ack_bits (cw_ack),
      .cu_code  (cw_cuc),
      .ru_code  (cw_ruc),
      .soft_rst (cw_soft),
      .ev_in    (ev_q),
      .cu_in    (cu_q),
      .ru_in    (ru_q),
      .ev_out   (ev_d),
      .cu_out   (cu_d),
      .ru_out   (ru_d)
   );

   cuseq_dispatch #(.HS_MASK(OP_HS_MASK)) u_disp (
      .go       (state == S_START),
      .opcode   (b_op),
      .done_in  (act_done),
      .start    (act_start),
      .needs_hs (hs_need),
      .done_hit (hs_done)
   );

   assign act_blk = ptr_q;
   assign word32  = {mem_rdata, half_q};
   assign ca_take = (state == S_IDLE) && (ca_cnt != '0);
   assign ca_inc  = ca && (ca_cnt != CA_MAX);

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_addr  = cb_base;
      mem_wdata = 16'h0000;
      case (state)
         S_RD_CW:   mem_addr = cb_base + OFS_W1;
         S_WR_CW: begin
            mem_we   = 1'b1;
            mem_addr = cb_base + OFS_W1;
         end
         S_HEAD_LO: mem_addr = cb_base + OFS_W2;
         S_HEAD_HI: mem_addr = cb_base + OFS_W3;
         S_WR_STAT: begin
            mem_we    = 1'b1;
            mem_wdata = pack_status(ev_q, cu_q, ru_q);
         end
         S_WR_BUSY: begin
            mem_we    = 1'b1;
            mem_addr  = ptr_q;
            mem_wdata = BLK_BUSY_WORD;
         end
         S_RD_BCMD: mem_addr = ptr_q + OFS_W1;
         S_WR_DONE: begin
            mem_we    = 1'b1;
            mem_addr  = ptr_q;
            mem_wdata = BLK_DONE_WORD;
         end
         S_LNK_LO:  mem_addr = ptr_q + OFS_W2;
         S_LNK_HI:  mem_addr = ptr_q + OFS_W3;
         default:   mem_req = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cu_q    <= CU_IDLE;
         ru_q    <= RU_SUSP;
         ev_q    <= 4'b0000;
         ptr_q   <= '0;
         pnull_q <= 1'b1;
         half_q  <= 16'h0000;
         cw_ack  <= 4'b0000;
         cw_cuc  <= 3'd0;
         cw_ruc  <= 3'd0;
         cw_soft <= 1'b0;
         b_op    <= 3'd0;
         b_eol   <= 1'b0;
         b_susp  <= 1'b0;
         b_intr  <= 1'b0;
         ca_cnt  <= '0;
         irq     <= 1'b0;
      end else begin
         irq    <= 1'b0;
         ca_cnt <= ca_cnt + CA_CNT_W'(ca_inc) - CA_CNT_W'(ca_take);
         case (state)
            S_IDLE: if (ca_take) state <= S_RD_CW;
            S_RD_CW: if (mem_ack) begin
               cw_ack  <= mem_rdata[15:12];
               cw_cuc  <= mem_rdata[10:8];
               cw_soft <= mem_rdata[7];
               cw_ruc  <= mem_rdata[6:4];
               state   <= S_WR_CW;
            end
            S_WR_CW: if (mem_ack) begin
               ev_q <= ev_d;
               cu_q <= cu_d;
               ru_q <= ru_d;
               if (cw_soft) pnull_q <= 1'b1;
               if (cu_d != CU_SUSP && (pnull_q || cw_soft)) state <= S_HEAD_LO;
               else                                          state <= S_WR_STAT;
            end
            S_HEAD_LO, S_LNK_LO: if (mem_ack) begin
               half_q <= mem_rdata;
               state  <= (state == S_HEAD_LO) ? S_HEAD_HI : S_LNK_HI;
            end
            S_HEAD_HI: if (mem_ack) begin
               ptr_q   <= word32[ADDR_W-1:0];
               pnull_q <= ptr_is_null(word32);
               state   <= S_WR_STAT;
            end
            S_WR_STAT: if (mem_ack) begin
               state <= (cu_q == CU_ACT && !pnull_q) ? S_WR_BUSY : S_IDLE;
            end
            S_WR_BUSY: if (mem_ack) state <= S_RD_BCMD;
            S_RD_BCMD: if (mem_ack) begin
               b_op   <= mem_rdata[2:0];
               b_eol  <= mem_rdata[15];
               b_susp <= mem_rdata[14];
               b_intr <= mem_rdata[13];
               state  <= S_START;
            end
            S_START: state <= hs_need ? S_WAIT : S_WR_DONE;
            S_WAIT: if (hs_done) state <= S_WR_DONE;
            S_WR_DONE: if (mem_ack) state <= S_LNK_LO;
            S_LNK_HI: if (mem_ack) begin
               ptr_q   <= word32[ADDR_W-1:0];
               pnull_q <= ptr_is_null(word32) || b_eol;
               if (b_susp) cu_q <= CU_SUSP;
               ev_q[3] <= b_intr;
               irq     <= b_intr;
               state   <= S_WR_STAT;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cuseq_chk.sv
module cuseq_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [15:0]       mem_wdata,
   input logic              mem_ack,
   input logic [7:0]        act_start,
   input logic              irq
);

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!mem_req && !irq && act_start == 8'h00)); // R1

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R14

   AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_start)); // R8

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_start != 8'h00) |=> (act_start == 8'h00)); // R8

   AST_START_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_start != 8'h00) |-> !mem_req); // R8

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R10

endmodule

bind cuseq_top cuseq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .act_start (act_start),
   .irq       (irq)
);

// File: tb/tb_cuseq_top.sv
`timescale 1ns/1ps
module tb_cuseq_top;
   localparam int AW = 12;
   localparam logic [AW-1:0] CB = 12'h040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ca = 1'b0;
   logic          mem_req, mem_we, mem_ack = 1'b0;
   logic [AW-1:0] mem_addr, act_blk;
   logic [15:0]   mem_wdata, mem_rdata = 16'h0;
   logic [7:0]    act_start, act_done = 8'h00;
   logic          irq;
   logic          clr_log = 1'b0;

   always #4 clk = ~clk;

   cuseq_top #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .ca(ca), .cb_base(CB),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .act_start(act_start), .act_done(act_done), .act_blk(act_blk), .irq(irq)
   );

   logic [15:0]   mem [0:2047];
   logic [AW-1:0] busy_log [0:63];
   logic [AW-1:0] hs_log [0:63];
   int            busy_n = 0, hs_n = 0, irq_n = 0;
   int            dly [0:7];

   // memory, action units and event logs
   always @(posedge clk) begin
      if (clr_log) begin
         busy_n <= 0; hs_n <= 0; irq_n <= 0;
      end else begin
         if (irq) irq_n <= irq_n + 1;
         if (mem_req && !mem_ack && mem_we && mem_wdata == 16'h4000 && busy_n < 64) begin
            busy_log[busy_n] <= mem_addr;
            busy_n <= busy_n + 1;
         end
         if (act_start != 8'h00 && hs_n < 64) begin
            hs_log[hs_n] <= act_blk;
            hs_n <= hs_n + 1;
         end
      end
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[mem_addr[AW-1:1]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[AW-1:1]];
      end else begin
         mem_ack <= 1'b0;
      end
      for (int k = 0; k < 8; k++) begin
         act_done[k] <= (dly[k] == 1);
         if (dly[k] > 0) dly[k] <= dly[k] - 1;
         if (act_start[k]) dly[k] <= 1 + int'($urandom % 4);
      end
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reference model state
   logic [3:0]    m_ev = 4'h0;
   logic [1:0]    m_cu = 2'd0;
   logic [2:0]    m_ru = 3'd1;
   bit            m_pnull = 1;
   logic [31:0]   m_ptr = 32'h0;
   logic [AW-1:0] e_busy [0:63];
   logic [AW-1:0] e_hs [0:63];
   int            e_bn, e_hn, e_irq;
   localparam logic [7:0] HS = 8'hFE;

   function automatic logic [31:0] rd32(input logic [AW-1:0] a);
      return {mem[(a + 12'd2) >> 1], mem[a >> 1]};
   endfunction
   function automatic bit nul(input logic [31:0] p);
      return p == 32'h0 || p == 32'hFFFF_FFFF;
   endfunction

   task automatic model_ca(input logic [15:0] cw);
      logic [15:0] c;
      logic [31:0] lk;
      m_ev = m_ev & ~cw[15:12];
      if (cw[10:8] == 3'd1) m_cu = 2'd2;
      if (cw[10:8] == 3'd4) begin m_cu = 2'd1; m_ev[1] = 1'b1; end
      if (cw[6:4] == 3'd1 || cw[6:4] == 3'd2) m_ru = 3'd0;
      if (cw[6:4] == 3'd3 || cw[6:4] == 3'd4) begin m_ru = 3'd1; m_ev[0] = 1'b1; end
      if (cw[7]) begin m_ev = 4'h0; m_cu = 2'd0; m_ru = 3'd1; m_pnull = 1; end
      if (m_cu != 2'd1 && m_pnull) begin
         m_ptr = rd32(CB + 12'd4);
         m_pnull = nul(m_ptr);
      end
      for (int g = 0; g < 60 && m_cu == 2'd2 && !m_pnull; g++) begin
         e_busy[e_bn] = m_ptr[AW-1:0]; e_bn++;
         c = mem[(m_ptr[AW-1:0] + 12'd2) >> 1];
         if (HS[c[2:0]]) begin e_hs[e_hn] = m_ptr[AW-1:0]; e_hn++; end
         lk = rd32(m_ptr[AW-1:0] + 12'd4);
         m_pnull = nul(lk) || c[15];
         m_ptr = lk;
         if (c[14]) m_cu = 2'd1;
         m_ev[3] = c[13];
         if (c[13]) e_irq++;
      end
   endtask

   task automatic wr_blk(input logic [AW-1:0] a, input logic [15:0] cmd, input logic [31:0] lk);
      mem[a >> 1]         = 16'h0;
      mem[(a + 12'd2) >> 1] = cmd;
      mem[(a + 12'd4) >> 1] = lk[15:0];
      mem[(a + 12'd6) >> 1] = lk[31:16];
   endtask

   task automatic set_head(input logic [AW-1:0] a);
      mem[(CB + 12'd4) >> 1] = 16'(a);
      mem[(CB + 12'd6) >> 1] = 16'h0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      int g = 0;
      while (q < 30 && g < 20000) begin
         @(negedge clk);
         g++;
         if (mem_req || act_start != 8'h00 || act_done != 8'h00) q = 0;
         else q++;
      end
   endtask

   task automatic run(input logic [15:0] cw, input bit dbl, input string tag);
      logic [15:0] exp_st;
      @(negedge clk); clr_log = 1'b1;
      @(negedge clk); clr_log = 1'b0;
      e_bn = 0; e_hn = 0; e_irq = 0;
      model_ca(cw);
      if (dbl) model_ca(16'h0000);
      exp_st = {m_ev, 2'b00, m_cu, 1'b0, m_ru, 4'b0000};
      mem[(CB + 12'd2) >> 1] = cw;
      ca = 1'b1; @(negedge clk); ca = 1'b0;
      if (dbl) begin
         repeat (3) @(negedge clk);
         ca = 1'b1; @(negedge clk); ca = 1'b0;
      end
      wait_quiet();
      chk({tag, " R6 status word"}, 32'(mem[CB >> 1]), 32'(exp_st));
      chk("R2 control word cleared", 32'(mem[(CB + 12'd2) >> 1]), 32'h0);
      chk("R7 busy write count", busy_n, e_bn);
      for (int i = 0; i < e_bn && i < busy_n; i++) begin
         chk("R7 busy order", 32'(busy_log[i]), 32'(e_busy[i]));
         chk("R7 completion word", 32'(mem[e_busy[i] >> 1]), 32'hA000);
      end
      chk("R8 handshake count", hs_n, e_hn);
      for (int i = 0; i < e_hn && i < hs_n; i++)
         chk("R8 dispatched block", 32'(hs_log[i]), 32'(e_hs[i]));
      chk("R10 irq pulses", irq_n, e_irq);
   endtask

   task automatic rand_list(input logic [AW-1:0] base);
      int nb = 1 + int'($urandom % 4);
      for (int i = 0; i < nb; i++) begin
         logic [15:0] c;
         logic [31:0] lk;
         c = 16'($urandom % 8);
         if ($urandom % 3 == 0) c[13] = 1'b1;
         if ($urandom % 6 == 0) c[14] = 1'b1;
         lk = 32'(base + 12'(16 * (i + 1)));
         if (i == nb - 1) begin
            case ($urandom % 3)
               0: lk = 32'h0;
               1: lk = 32'hFFFF_FFFF;
               default: begin c[15] = 1'b1; lk = 32'(base); end
            endcase
         end
         wr_blk(base + 12'(16 * i), c, lk);
      end
      set_head(base);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] cw;
      void'($urandom(32'h0000_5EED));
      for (int k = 0; k < 8; k++) dly[k] = 0;
      for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 mem_req after reset", 32'(mem_req), 32'h0);
      chk("R1 irq after reset", 32'(irq), 32'h0);
      chk("R1 act_start after reset", 32'(act_start), 32'h0);

      // list A: three blocks, interrupt on first, end flag on last
      wr_blk(12'h100, 16'h2001, 32'h110);
      wr_blk(12'h110, 16'h0000, 32'h120);
      wr_blk(12'h120, 16'h8004, 32'h100);
      set_head(12'h100);
      run(16'h0000, 0, "R1 idle head load");
      chk("R1 reset status value", 32'(mem[CB >> 1]), 32'h0010);
      run(16'h0100, 0, "R11 walk from loaded pointer");
      chk("R10 event 15 cleared by last block", 32'(mem[CB >> 1]), 32'h0210);

      // list B: suspend after first, all-ones link on second
      wr_blk(12'h140, 16'h4002, 32'h150);
      wr_blk(12'h150, 16'h2003, 32'hFFFF_FFFF);
      set_head(12'h140);
      run(16'h0110, 0, "R9 suspend");
      chk("R9 suspended after one block", 32'(mem[CB >> 1]), 32'h0100);
      run(16'h0100, 0, "R9 resume");
      chk("R10 event 15 set", 32'(mem[CB >> 1]), 32'h8200);
      run(16'h8430, 0, "R4 R5 abort");
      chk("R4 abort status", 32'(mem[CB >> 1]), 32'h3110);
      run(16'h3000, 0, "R3 acknowledge");
      chk("R3 events cleared", 32'(mem[CB >> 1]), 32'h0110);
      run(16'h0750, 0, "R4 R5 unknown codes");
      chk("R5 unknown codes ignored", 32'(mem[CB >> 1]), 32'h0110);
      run(16'h0180, 0, "R13 soft reset");
      chk("R13 reset status", 32'(mem[CB >> 1]), 32'h0010);

      // list C for a strobe arriving mid-walk
      wr_blk(12'h180, 16'h0001, 32'h190);
      wr_blk(12'h190, 16'h0005, 32'h1A0);
      wr_blk(12'h1A0, 16'h2006, 32'h0);
      set_head(12'h180);
      run(16'h0100, 1, "R12 strobe during walk");

      for (int n = 0; n < 40; n++) begin
         rand_list(12'h200 + 12'(n * 64));
         cw = 16'($urandom) & 16'hF070;
         case ($urandom % 4)
            0: cw[10:8] = 3'd4;
            1, 2: cw[10:8] = 3'd1;
            default: cw[10:8] = 3'($urandom % 8);
         endcase
         if ($urandom % 8 == 0) cw[7] = 1'b1;
         run(cw, ($urandom % 5 == 0), "R11 random");
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule